// File: doc/BRIEF.md
# Half-Cycle Serial Pattern Generator

This block plays a serial bit pattern, fixed by parameters, over and over. Each pattern bit lasts half a period of the input clock, so the output can change on both the rising and the falling edge. The output is clean enough to clock other logic.

The block holds its state in two circular shift lanes of equal length. One lane rotates on the rising edge and the other on the falling edge. The output is the XOR of the two lanes' top bits, and no gate follows that XOR. The lane contents are worked out while the design is built. Each pattern bit is the XOR of two neighbouring entries of a running-parity sequence, and that sequence is dealt alternately into the two lanes. At any edge only one lane moves, so only one XOR input changes, and the output has no hazard window.

A synchronous load input parks the generator with its output low. After load is released, the pattern starts from its first bit at the next rising edge.

Top module: `halfbit_pattern_gen`

## Requirements
- R1: After release, pattern bit k appears during half-cycle k, counted from the first rising edge after load is sampled low. Bit 0 is the most significant bit of the pattern parameter. The sequence repeats every pattern-length half-cycles. With the default 6-bit pattern 100110, the first twelve half-cycles read 1,0,0,1,1,0,1,0,0,1,1,0.
- R2: The output changes only at clock edges. It is the same 3 ns and 8 ns after any edge of the 20 ns clock.
- R3: Load is acted on only when a rising edge samples it. A load pulse that is raised after a rising edge and dropped before the next one leaves the running sequence unchanged.
- R4: The output is 0 from the first falling edge after a rising edge that samples load high. It stays 0 through the falling edge that follows release, and it leaves 0 only at the first rising edge that samples load low.
- R5: At any clock edge only one XOR input may change. The rising-edge lane top bit never changes at a falling edge, and the falling-edge lane top bit never changes at a rising edge.
- R6: Each lane is as long as the pattern. Each lane returns to its starting contents every pattern-length clock cycles. This holds for odd lengths and for patterns with odd parity. The output stays correct for a 5-bit pattern with odd parity (10110) and for a 4-bit pattern with even parity (1100).
- R7: A load applied partway through the pattern restarts it. After the release, the output starts again from pattern bit 0.
- R8: The shortest pattern length, 2, is supported. The 2-bit pattern 10 gives a square wave at the clock rate, high in the first half of each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock. Both of its edges advance the pattern |
| load | input | 1 | Synchronous park and restart, active high, sampled at the rising edge |
| pat_out | output | 1 | Pattern output, the XOR of the two lane top bits |

## Verification
The release edge is the one place where two functions share an edge. At that rising edge the rising lane swaps its parked contents for its seed, while the falling lane must still hold the seed it reloaded on the falling edge just before. The bench provokes this on every release and checks the quiet level at the falling edge before the release. It then checks that the first bit appears exactly at the next rising edge. A second case drops a load pulse between two rising edges while the falling lane rotates, and judges it by an unbroken output sequence.

// File: rtl/hpg_pkg.sv
package hpg_pkg;

  // Widest pattern the elaboration helpers accept.
  localparam int unsigned MAXW = 64;
  typedef logic [MAXW-1:0] wide_t;

  // Pattern bit emitted in half-cycle idx (bit 0 is the pattern MSB).
  function automatic logic pick(wide_t pat, int unsigned len, int unsigned idx);
    int unsigned k;
    k = len - 1 - (idx % len);
    return pat[k[5:0]];
  endfunction

  // Starting contents of one lane. The running parity c[j] = c[j-1] ^ p[j],
  // with c[-1] = 0, is dealt out: even j to the rising lane, odd j to the
  // falling lane. The falling lane's top bit is c[-1], shown until its first
  // falling edge.
  function automatic wide_t lane_seed(wide_t pat, int unsigned len, bit fall_lane);
    wide_t       s;
    logic        c;
    int unsigned k;
    s = '0;
    c = 1'b0;
    for (int unsigned j = 0; j < 2 * len; j++) begin
      c = c ^ pick(pat, len, j);
      if (!fall_lane && (j % 2 == 0)) begin
        k = len - 1 - j / 2;
        s[k[5:0]] = c;
      end else if (fall_lane && (j % 2 == 1) && (j / 2 + 2 <= len)) begin
        k = len - 2 - j / 2;
        s[k[5:0]] = c;
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/hpg_hold.sv
module hpg_hold #(
  parameter int unsigned PAT_LEN = 6,
  localparam int unsigned CW = (PAT_LEN < 2) ? 1 : $clog2(PAT_LEN)
) (
  input  logic          clk,
  input  logic          load,
  output logic          hold_q,
  output logic [CW-1:0] cyc
);

  // hold_q marks that the last rising edge sampled load high. It parks the
  // falling lane and triggers reseeding of the rising lane at release.
  always_ff @(posedge clk) begin
    hold_q <= load;
  end

  // Rising-edge cycle index within the pattern, zero after the release edge.
  always_ff @(posedge clk) begin
    if (load || hold_q) begin
      cyc <= '0;
    end else if (cyc == CW'(PAT_LEN - 1)) begin
      cyc <= '0;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

endmodule

// File: rtl/hpg_lane.sv
module hpg_lane #(
  parameter int unsigned  N       = 6,
  parameter bit           ON_RISE = 1'b1,
  parameter logic [N-1:0] SEED    = '0,
  parameter logic [N-1:0] PARK    = '0,
  localparam int unsigned PW = (N < 2) ? 1 : $clog2(N)
) (
  input  logic clk,
  input  logic park,
  input  logic seed,
  output logic msb
);

  logic [N-1:0]  sr;
  logic [N-1:0]  nxt;
  logic [PW-1:0] ph;
  logic          armed;

  // Park contents win over reseeding; otherwise rotate toward the MSB.
  always_comb begin
    if (park) begin
      nxt = PARK;
    end else if (seed) begin
      nxt = SEED;
    end else begin
      nxt = {sr[N-2:0], sr[N-1]};
    end
  end

  assign msb = sr[N-1];

  generate
    if (ON_RISE) begin : g_rise
      always_ff @(posedge clk) begin
        sr <= nxt;
        if (park) begin
          armed <= 1'b0;
          ph    <= '0;
        end else if (seed) begin
          armed <= 1'b1;
          ph    <= '0;
        end else begin
          ph <= (ph == PW'(N - 1)) ? '0 : ph + 1'b1;
        end
      end

      // R6: the lane comes back to its seed every N rotations.
      p_wrap_r6: assert property (@(posedge clk) disable iff (park || seed)
        (armed && ph == '0) |-> (sr == SEED));
    end else begin : g_fall
      always_ff @(negedge clk) begin
        sr <= nxt;
        if (park) begin
          armed <= 1'b0;
          ph    <= '0;
        end else if (seed) begin
          armed <= 1'b1;
          ph    <= '0;
        end else begin
          ph <= (ph == PW'(N - 1)) ? '0 : ph + 1'b1;
        end
      end

      // R6: the lane comes back to its seed every N rotations.
      p_wrap_r6: assert property (@(negedge clk) disable iff (park || seed)
        (armed && ph == '0) |-> (sr == SEED));
    end
  endgenerate

endmodule

// File: rtl/halfbit_pattern_gen.sv
module halfbit_pattern_gen
  import hpg_pkg::*;
#(
  parameter int unsigned          PAT_LEN = 6,
  parameter logic [PAT_LEN-1:0]   PATTERN = 6'b100110
) (
  input  logic clk,
  input  logic load,
  output logic pat_out
);

  localparam int unsigned CW     = (PAT_LEN < 2) ? 1 : $clog2(PAT_LEN);
  localparam wide_t       PAT_W  = wide_t'(PATTERN);
  localparam wide_t       RISE_W = lane_seed(PAT_W, PAT_LEN, 1'b0);
  localparam wide_t       FALL_W = lane_seed(PAT_W, PAT_LEN, 1'b1);

  logic          hold_q;
  logic [CW-1:0] cyc;
  logic          rise_msb;
  logic          fall_msb;

  hpg_hold #(.PAT_LEN(PAT_LEN)) u_hold (
    .clk    (clk),
    .load   (load),
    .hold_q (hold_q),
    .cyc    (cyc)
  );

  // Rising lane: parked at all zeros while load is sampled, seeded at release.
  hpg_lane #(
    .N       (PAT_LEN),
    .ON_RISE (1'b1),
    .SEED    (RISE_W[PAT_LEN-1:0]),
    .PARK    ('0)
  ) u_rise (
    .clk  (clk),
    .park (load),
    .seed (hold_q & ~load),
    .msb  (rise_msb)
  );

  // Falling lane: reloaded with its seed (top bit 0) on every held cycle.
  hpg_lane #(
    .N       (PAT_LEN),
    .ON_RISE (1'b0),
    .SEED    (FALL_W[PAT_LEN-1:0]),
    .PARK    ('0)
  ) u_fall (
    .clk  (clk),
    .park (1'b0),
    .seed (hold_q),
    .msb  (fall_msb)
  );

  // Nothing may follow this gate.
  assign pat_out = rise_msb ^ fall_msb;

  // Checker-side captures of each top bit at the opposite edge.
  logic rise_at_fall;
  logic fall_at_rise;
  always_ff @(negedge clk) rise_at_fall <= rise_msb;
  always_ff @(posedge clk) fall_at_rise <= fall_msb;

  // R5: the rising lane top bit does not move at a falling edge.
  p_rise_still_r5: assert property (@(posedge clk) disable iff (load)
    rise_msb == rise_at_fall);

  // R5: the falling lane top bit does not move at a rising edge.
  p_fall_still_r5: assert property (@(negedge clk) disable iff (load)
    fall_msb == fall_at_rise);

  // R1: first half of each running cycle carries bit 2*cyc.
  p_first_half_r1: assert property (@(negedge clk) disable iff (load)
    !hold_q |-> (pat_out == pick(PAT_W, PAT_LEN, 2 * int'(cyc))));

  // R1: second half carries bit 2*cyc+1.
  p_second_half_r1: assert property (@(posedge clk) disable iff (load)
    !hold_q |-> (pat_out == pick(PAT_W, PAT_LEN, 2 * int'(cyc) + 1)));

  // R4: output is low while parked.
  p_quiet_r4: assert property (@(posedge clk) disable iff (load && !hold_q)
    hold_q |-> !pat_out);

endmodule

// File: tb/sim_halfbit_pattern_gen.sv
module sim_halfbit_pattern_gen;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic load = 1'b1;
  logic o0, o1, o2, o3;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #10 clk = ~clk;

  halfbit_pattern_gen u0 (.clk(clk), .load(load), .pat_out(o0));
  halfbit_pattern_gen #(.PAT_LEN(5), .PATTERN(5'b10110)) u1 (.clk(clk), .load(load), .pat_out(o1));
  halfbit_pattern_gen #(.PAT_LEN(4), .PATTERN(4'b1100))  u2 (.clk(clk), .load(load), .pat_out(o2));
  halfbit_pattern_gen #(.PAT_LEN(2), .PATTERN(2'b10))    u3 (.clk(clk), .load(load), .pat_out(o3));

  // R1: expected output of u0, one period of its XOR sequence.
  localparam bit EXP0 [0:11] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0,
                                 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

  function automatic logic ebit(logic [7:0] pat, int len, int j);
    return pat[len - 1 - (j % len)];
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic all_low(input string req);
    chk(req, o0, 1'b0);
    chk(req, o1, 1'b0);
    chk(req, o2, 1'b0);
    chk(req, o3, 1'b0);
  endtask

  task automatic cmp_all(input string req, input int j);
    chk({req, " R1 u0"}, o0, EXP0[j % 12]);
    chk({req, " R6 u1"}, o1, ebit(8'b10110, 5, j));
    chk({req, " R6 u2"}, o2, ebit(8'b1100, 4, j));
    chk({req, " R8 u3"}, o3, ebit(8'b10, 2, j));
  endtask

  // Walk half-cycles; every edge also exercises the R5 single-input checks.
  task automatic run(input string req, input int start, input int count);
    for (int j = start; j < start + count; j++) begin
      if (j % 2 == 0) @(posedge clk);
      else            @(negedge clk);
      #3;
      cmp_all(req, j);
      #5;
      chk("R2 stable after edge", o0, EXP0[j % 12]);
    end
  endtask

  initial begin
    // R4: parked output after reset.
    repeat (3) @(posedge clk);
    #3 all_low("R4 park rise");
    @(negedge clk);
    #3 all_low("R4 park fall");
    @(posedge clk);
    #2 load = 1'b0;
    @(negedge clk);
    #3 all_low("R4 before first rise");

    run("R1", 0, 40);

    // R3: load pulse between rising edges must be ignored.
    @(posedge clk);
    #3 cmp_all("R3", 40);
    load = 1'b1;
    @(negedge clk);
    #3 cmp_all("R3", 41);
    #3 load = 1'b0;
    run("R3", 42, 10);

    // R7: reload partway through the pattern.
    @(posedge clk);
    #2 load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #3 all_low("R7 mid reload");
    @(posedge clk);
    #2 load = 1'b0;
    run("R7", 0, 24);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule